// File: doc/BRIEF.md
# DMA Bus-Master Transfer Sequencer

This block runs the bus-owning half of a single-byte DMA engine. When any enabled channel raises a request, the sequencer asks the processor for the bus. It then waits for the processor to grant it. From that point it performs one byte transfer per machine cycle.

Each machine cycle has a fixed structure. In the first state the upper address byte is placed on the shared data pins with a strobe, so that an external latch can hold it. The lower address byte is driven on dedicated address outputs. The channel acknowledge and the read/write strobe pairs follow. A ready input can stretch the cycle with wait states. In the last state the sequencer tells the channel register file to step the address up and the count down.

Priority selection and register programming live outside. An external arbiter presents the chosen channel number together with that channel's current address, remaining count and direction. The register file applies the update pulse.

The state machine has seven states:
- `ST_IDLE`: not bus master.
- `ST_HOLD`: bus requested, waiting for acknowledge.
- `ST_T1`: address high byte on the data pins, latch strobe high.
- `ST_T2`: read strobe and acknowledge start.
- `ST_T3`: write strobe starts, ready is sampled.
- `ST_TW`: wait state.
- `ST_T4`: update and terminal count.

The transitions are:
- IDLE→HOLD on any request.
- HOLD→IDLE when all requests vanish.
- HOLD→T1 on hold acknowledge.
- T1→T2→T3 unconditionally.
- T3→T4 when ready is high; T3→TW when ready is low.
- TW→TW while ready stays low; TW→T4 when ready returns.
- T4→T1 when a request other than a just-terminated channel remains and acknowledge is still high.
- T4→IDLE otherwise.

Top module: `dma_xfer_seq`

## Requirements
- R1: Out of reset and whenever no transfer is active, `hold_req`, `db_oe`, `addr_oe`, `ctl_oe`, `adr_stb`, `upd_en` and `tc_pulse` are 0, and all of `dack_n`, `ior_n`, `iow_n`, `memr_n` and `memw_n` are 1.
- R2: A nonzero `dreq` raises `hold_req` one clock later. No transfer state (`adr_stb` high) occurs before `hold_ack` is seen high.
- R3: In the first clock of each byte, `adr_stb` and `db_oe` are 1 and `db_out` equals address bits 15..8. From the second clock to the end of the byte, `db_oe` is 0.
- R4: For the whole byte, `addr_oe` is 1 and `addr_lo` equals address bits 7..0 without change.
- R5: When `xfer_wr`=1 (a write into memory), `ior_n` is low from the second clock to the end of the byte and `memw_n` is low from the third clock to the end, while `memr_n` and `iow_n` stay high. When `xfer_wr`=0, `memr_n` and `iow_n` take those two roles and `ior_n` and `memw_n` stay high.
- R6: With `ready` high, a byte takes exactly 4 clocks from `adr_stb` to `upd_en`.
- R7: Each clock that `ready` is sampled low in the third state or in a wait state adds one wait state before the fourth state. The strobes stay asserted during the waits.
- R8: Bit `dack_n[c]` of the serviced channel c is low from the second clock to the end of the byte, as one pulse per byte. All other `dack_n` bits stay high.
- R9: `upd_en` is a one-clock pulse in the last clock of each byte, and `upd_chan` gives the serviced channel.
- R10: `tc_pulse` is high in the last clock of a byte exactly when the channel count presented at the start of that byte was 0.
- R11: After a byte, if a request remains (the channel just terminated does not count) and `hold_ack` is high, the next byte starts on the very next clock. Otherwise `hold_req` is 0 on the next clock.
- R12: If every request goes away while the sequencer is waiting for `hold_ack`, `hold_req` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NCH | Enabled channel requests |
| sel_chan | input | CHW | Channel chosen by the external arbiter |
| cur_addr | input | AW | Current address of the chosen channel |
| cur_cnt | input | CW | Remaining count of the chosen channel (0 = last byte) |
| xfer_wr | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| hold_ack | input | 1 | Bus grant from the processor |
| ready | input | 1 | Low inserts wait states |
| hold_req | output | 1 | Bus request to the processor |
| db_out | output | 8 | Address high byte for the external latch |
| db_oe | output | 1 | Data pin drive enable |
| adr_stb | output | 1 | Address latch strobe |
| addr_lo | output | 8 | Address low byte |
| addr_oe | output | 1 | Address output enable |
| ctl_oe | output | 1 | Strobe output enable |
| ior_n | output | 1 | Peripheral read strobe, active low |
| iow_n | output | 1 | Peripheral write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| dack_n | output | NCH | Channel acknowledges, active low |
| tc_pulse | output | 1 | Terminal-count pulse |
| upd_en | output | 1 | Address/count step pulse to the register file |
| upd_chan | output | CHW | Channel to step |

## Verification
Single-channel bursts in both directions tell the strobe pairs apart. They also show which strobe starts a clock early. Wait counts of zero, one and two separate the fixed four-clock cycle from the stretched one and confirm that waits sit only before the fourth state. Two channels requesting together, with different directions, check that the next byte follows immediately when another channel takes over after terminal count, and that the bus request drops only once. An address crossing a 256-byte boundary checks that the latched high byte tracks the stepped address. A request withdrawn before grant checks that the bus request is abandoned.

// File: rtl/dmaseq_pkg.sv
`timescale 1ns/1ps
package dmaseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } seq_state_t;

    function automatic logic is_master(seq_state_t s);
        return (s == ST_T1) || (s == ST_T2) || (s == ST_T3) ||
               (s == ST_TW) || (s == ST_T4);
    endfunction

    function automatic logic read_phase(seq_state_t s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
    endfunction

    function automatic logic write_phase(seq_state_t s);
        return (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/dmaseq_fsm.sv
`timescale 1ns/1ps
module dmaseq_fsm
    import dmaseq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_vec,
    input  logic [NCH-1:0]   tc_mask,
    input  logic             hold_ack,
    input  logic             ready,
    output seq_state_t       state
);

    seq_state_t nxt;
    logic       any_req;
    logic       more_req;

    assign any_req  = |req_vec;
    assign more_req = |(req_vec & ~tc_mask);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (any_req) nxt = ST_HOLD;
            ST_HOLD: begin
                if (!any_req)      nxt = ST_IDLE;
                else if (hold_ack) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   if (ready) nxt = ST_T4;
            ST_T4:   nxt = (more_req && hold_ack) ? ST_T1 : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // R2: no transfer state without the grant
    p_grant_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hold_ack) |=> (state != ST_T1));

    // R7: a wait state is only entered from the third state or another wait
    p_wait_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TW) |-> ($past(state) == ST_T3 || $past(state) == ST_TW));

    // R7: ready low in T3/TW keeps the cycle waiting
    p_ready_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3 || state == ST_TW) && !ready) |=> (state == ST_TW));

    // R12: withdrawn requests abandon the bus request
    p_abandon_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && req_vec == '0) |=> (state == ST_IDLE));

endmodule

// File: rtl/dmaseq_capture.sv
`timescale 1ns/1ps
module dmaseq_capture #(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    parameter  int CW  = 14,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CHW-1:0]   sel_chan,
    input  logic [AW-1:0]    cur_addr,
    input  logic [CW-1:0]    cur_cnt,
    input  logic             xfer_wr,
    output logic [CHW-1:0]   cap_chan,
    output logic [7:0]       cap_lo,
    output logic             cap_wr,
    output logic             cap_term,
    output logic [NCH-1:0]   tc_mask
);

    logic [AW-9:0] hi_unused;
    assign hi_unused = cur_addr[AW-1:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_chan <= '0;
            cap_lo   <= '0;
            cap_wr   <= 1'b0;
            cap_term <= 1'b0;
        end else if (load) begin
            cap_chan <= sel_chan;
            cap_lo   <= cur_addr[7:0];
            cap_wr   <= xfer_wr;
            cap_term <= (cur_cnt == '0) && (hi_unused == hi_unused);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_tcm
        assign tc_mask[g] = cap_term && (cap_chan == CHW'(g));
    end

    // R10: at most one channel can be terminating
    p_tc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_mask));

endmodule

// File: rtl/dmaseq_drive.sv
`timescale 1ns/1ps
module dmaseq_drive
    import dmaseq_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic [AW-1:0]    cur_addr,
    input  logic [CHW-1:0]   cap_chan,
    input  logic [7:0]       cap_lo,
    input  logic             cap_wr,
    input  logic             cap_term,
    output logic             hold_req,
    output logic [7:0]       db_out,
    output logic             db_oe,
    output logic             adr_stb,
    output logic [7:0]       addr_lo,
    output logic             addr_oe,
    output logic             ctl_oe,
    output logic             ior_n,
    output logic             iow_n,
    output logic             memr_n,
    output logic             memw_n,
    output logic [NCH-1:0]   dack_n,
    output logic             tc_pulse,
    output logic             upd_en,
    output logic [CHW-1:0]   upd_chan
);

    logic rd_act;
    logic wr_act;

    // output process
    always_comb begin
        rd_act   = read_phase(state);
        wr_act   = write_phase(state);
        hold_req = (state != ST_IDLE);
        addr_oe  = is_master(state);
        ctl_oe   = is_master(state);
        db_out   = '0;
        db_oe    = 1'b0;
        adr_stb  = 1'b0;
        addr_lo  = '0;
        upd_en   = 1'b0;
        tc_pulse = 1'b0;
        unique case (state)
            ST_T1: begin
                db_out  = cur_addr[AW-1:AW-8];
                db_oe   = 1'b1;
                adr_stb = 1'b1;
                addr_lo = cur_addr[7:0];
            end
            ST_T2, ST_T3, ST_TW: addr_lo = cap_lo;
            ST_T4: begin
                addr_lo  = cap_lo;
                upd_en   = 1'b1;
                tc_pulse = cap_term;
            end
            default: ;
        endcase
        ior_n    = !(rd_act &&  cap_wr);
        memr_n   = !(rd_act && !cap_wr);
        memw_n   = !(wr_act &&  cap_wr);
        iow_n    = !(wr_act && !cap_wr);
        upd_chan = cap_chan;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ack
        assign dack_n[g] = !(rd_act && (cap_chan == CHW'(g)));
    end

    // R8: at most one acknowledge active
    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n));

    // R5: never more than one read and one write strobe together
    p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 2);

    // R5: memory write only begins while the peripheral read is already active
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memw_n) |-> ($past(!ior_n) && !ior_n));

    // R3: data pins released right after the latch strobe
    p_db_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb |=> !db_oe);

    // R4: low address steady while the acknowledge is held
    p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dack_n != '0) && $past(~dack_n != '0)) |-> $stable(addr_lo));

    // R9: update is a single-clock pulse
    p_upd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> !upd_en);

    // R1: strobes idle whenever not driving the bus
    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (ior_n && iow_n && memr_n && memw_n && (&dack_n)));

endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
    import dmaseq_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int AW  = 16,
    parameter  int CW  = 14,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   dreq,
    input  logic [CHW-1:0]   sel_chan,
    input  logic [AW-1:0]    cur_addr,
    input  logic [CW-1:0]    cur_cnt,
    input  logic             xfer_wr,
    input  logic             hold_ack,
    input  logic             ready,
    output logic             hold_req,
    output logic [7:0]       db_out,
    output logic             db_oe,
    output logic             adr_stb,
    output logic [7:0]       addr_lo,
    output logic             addr_oe,
    output logic             ctl_oe,
    output logic             ior_n,
    output logic             iow_n,
    output logic             memr_n,
    output logic             memw_n,
    output logic [NCH-1:0]   dack_n,
    output logic             tc_pulse,
    output logic             upd_en,
    output logic [CHW-1:0]   upd_chan
);

    seq_state_t          state;
    logic [CHW-1:0]      cap_chan;
    logic [7:0]          cap_lo;
    logic                cap_wr;
    logic                cap_term;
    logic [NCH-1:0]      tc_mask;
    logic                load;

    assign load = (state == ST_T1);

    dmaseq_fsm #(.NCH(NCH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vec  (dreq),
        .tc_mask  (tc_mask),
        .hold_ack (hold_ack),
        .ready    (ready),
        .state    (state)
    );

    dmaseq_capture #(.NCH(NCH), .AW(AW), .CW(CW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .sel_chan (sel_chan),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .xfer_wr  (xfer_wr),
        .cap_chan (cap_chan),
        .cap_lo   (cap_lo),
        .cap_wr   (cap_wr),
        .cap_term (cap_term),
        .tc_mask  (tc_mask)
    );

    dmaseq_drive #(.NCH(NCH), .AW(AW)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cur_addr (cur_addr),
        .cap_chan (cap_chan),
        .cap_lo   (cap_lo),
        .cap_wr   (cap_wr),
        .cap_term (cap_term),
        .hold_req (hold_req),
        .db_out   (db_out),
        .db_oe    (db_oe),
        .adr_stb  (adr_stb),
        .addr_lo  (addr_lo),
        .addr_oe  (addr_oe),
        .ctl_oe   (ctl_oe),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .memr_n   (memr_n),
        .memw_n   (memw_n),
        .dack_n   (dack_n),
        .tc_pulse (tc_pulse),
        .upd_en   (upd_en),
        .upd_chan (upd_chan)
    );

    // R11: a terminated channel alone never starts another byte
    p_tc_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4 && (dreq & ~tc_mask) == '0) |=> (state == ST_IDLE));

endmodule

// File: tb/sim_dma_xfer_seq.sv
`timescale 1ns/1ps
module sim_dma_xfer_seq;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 14;

    typedef struct {
        int chan;
        int addr;
        bit wr;
        bit tc;
        int waits;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     dreq;
    logic [1:0]     sel_chan;
    logic [15:0]    cur_addr;
    logic [13:0]    cur_cnt;
    logic           xfer_wr;
    logic           hold_ack = 1'b0;
    logic           ready = 1'b1;
    logic           hold_req, db_oe, adr_stb, addr_oe, ctl_oe;
    logic           ior_n, iow_n, memr_n, memw_n, tc_pulse, upd_en;
    logic [7:0]     db_out, addr_lo;
    logic [3:0]     dack_n;
    logic [1:0]     upd_chan;

    // register-file and peripheral model
    logic [15:0]    addr_m [4];
    logic [13:0]    cnt_m  [4];
    logic           wr_m   [4];
    logic [3:0]     en_m = 4'b0;
    logic [3:0]     drq_raw = 4'b0;
    bit             ack_en = 1'b0;
    logic [1:0]     ack_pipe = 2'b0;
    int             wait_cfg = 0;
    int             wleft = 0;

    int             checks = 0;
    int             errors = 0;
    int             cycles = 0;
    exp_t           q[$];

    always #2.5 clk = ~clk;

    dma_xfer_seq #(.NCH(NCH), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .sel_chan(sel_chan),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .xfer_wr(xfer_wr),
        .hold_ack(hold_ack), .ready(ready), .hold_req(hold_req),
        .db_out(db_out), .db_oe(db_oe), .adr_stb(adr_stb), .addr_lo(addr_lo),
        .addr_oe(addr_oe), .ctl_oe(ctl_oe), .ior_n(ior_n), .iow_n(iow_n),
        .memr_n(memr_n), .memw_n(memw_n), .dack_n(dack_n),
        .tc_pulse(tc_pulse), .upd_en(upd_en), .upd_chan(upd_chan)
    );

    always_comb begin
        dreq     = drq_raw & en_m;
        sel_chan = 2'd0;
        for (int i = 3; i >= 0; i--) if (dreq[i]) sel_chan = 2'(i);
        cur_addr = addr_m[sel_chan];
        cur_cnt  = cnt_m[sel_chan];
        xfer_wr  = wr_m[sel_chan];
    end

    always @(posedge clk) begin
        if (upd_en) begin
            addr_m[upd_chan] <= addr_m[upd_chan] + 16'd1;
            cnt_m[upd_chan]  <= cnt_m[upd_chan] - 14'd1;
            if (cnt_m[upd_chan] == 14'd0) en_m[upd_chan] <= 1'b0;
        end
    end

    // processor grant with two-clock latency, ready generator
    always @(negedge clk) begin
        ack_pipe = {ack_pipe[0], hold_req && ack_en};
        hold_ack = ack_pipe[1] && hold_req && ack_en;
        if (adr_stb) wleft = wait_cfg;
        if ((!memw_n || !iow_n) && wleft > 0) begin
            ready = 1'b0;
            wleft--;
        end else begin
            ready = 1'b1;
        end
    end

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    task automatic arm(int ch, int addr, int n, bit wr);
        addr_m[ch] = 16'(addr);
        cnt_m[ch]  = 14'(n - 1);
        wr_m[ch]   = wr;
        en_m[ch]   = 1'b1;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.chan  = ch;
            e.addr  = (addr + i) & 16'hFFFF;
            e.wr    = wr;
            e.tc    = (i == n - 1);
            e.waits = wait_cfg;
            q.push_back(e);
        end
    endtask

    // monitor / scoreboard
    bit  mon_busy = 0;
    bit  expect_next = 0;
    bit  expect_idle = 0;
    int  m_hi, m_lo, m_cyc, m_rel, m_abad, n_ior, n_iow, n_memr, n_memw, n_ack, m_ch;
    int  hold_falls = 0;
    bit  prev_hold = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold && !hold_req) hold_falls++;
            prev_hold = hold_req;
            if (expect_next) begin
                chk(adr_stb == 1'b1, "R11", "next byte starts at once", int'(adr_stb), 1);
                expect_next = 0;
            end
            if (expect_idle) begin
                chk(hold_req == 1'b0, "R11", "hold dropped after last byte", int'(hold_req), 0);
                expect_idle = 0;
            end
            if (adr_stb) begin
                mon_busy = 1;
                m_hi = int'(db_out); m_lo = int'(addr_lo); m_cyc = 1;
                m_rel = 0; m_abad = 0; n_ior = 0; n_iow = 0; n_memr = 0;
                n_memw = 0; n_ack = 0; m_ch = -1;
                chk(db_oe && addr_oe, "R3", "data/address enables in first clock",
                    int'({db_oe, addr_oe}), 3);
            end else if (mon_busy) begin
                m_cyc++;
                if (db_oe) m_rel++;
                if (!addr_oe || int'(addr_lo) != m_lo) m_abad++;
                if (!ior_n)  n_ior++;
                if (!iow_n)  n_iow++;
                if (!memr_n) n_memr++;
                if (!memw_n) n_memw++;
                if ($countones(~dack_n) == 1) begin
                    n_ack++;
                    for (int i = 0; i < 4; i++) if (!dack_n[i]) m_ch = i;
                end
                if (upd_en) begin
                    exp_t e;
                    mon_busy = 0;
                    if (q.size() == 0) begin
                        chk(0, "R9", "unexpected byte", m_ch, -1);
                    end else begin
                        e = q.pop_front();
                        chk(m_hi == (e.addr >> 8), "R3", "latched high byte", m_hi, e.addr >> 8);
                        chk(m_lo == (e.addr & 255), "R4", "low address", m_lo, e.addr & 255);
                        chk(m_abad == 0, "R4", "low address held", m_abad, 0);
                        chk(m_rel == 0, "R3", "data pins released", m_rel, 0);
                        chk(m_cyc == 4 + e.waits, e.waits == 0 ? "R6" : "R7",
                            "byte length", m_cyc, 4 + e.waits);
                        chk(m_ch == e.chan && n_ack == m_cyc - 1, "R8", "acknowledge channel",
                            m_ch * 100 + n_ack, e.chan * 100 + m_cyc - 1);
                        chk(int'(upd_chan) == e.chan, "R9", "update channel", int'(upd_chan), e.chan);
                        chk(tc_pulse == e.tc, "R10", "terminal count", int'(tc_pulse), int'(e.tc));
                        if (e.wr)
                            chk(n_ior == m_cyc - 1 && n_memw == m_cyc - 2 && n_memr == 0 && n_iow == 0,
                                "R5", "write-cycle strobes", n_ior * 10 + n_memw, (m_cyc - 1) * 10 + m_cyc - 2);
                        else
                            chk(n_memr == m_cyc - 1 && n_iow == m_cyc - 2 && n_ior == 0 && n_memw == 0,
                                "R5", "read-cycle strobes", n_memr * 10 + n_iow, (m_cyc - 1) * 10 + m_cyc - 2);
                        if (q.size() != 0) expect_next = 1;
                        else               expect_idle = 1;
                    end
                end
            end
        end
    end

    task automatic check_idle(string tag);
        chk(!hold_req && !db_oe && !addr_oe && !ctl_oe && !adr_stb && !upd_en && !tc_pulse,
            tag, "enables idle", int'({hold_req, db_oe, addr_oe, ctl_oe}), 0);
        chk(dack_n == 4'hF && ior_n && iow_n && memr_n && memw_n,
            tag, "strobes idle", int'({dack_n, ior_n, iow_n, memr_n, memw_n}), 255);
    endtask

    task automatic finish_burst();
        int n = 0;
        while ((q.size() != 0 || mon_busy || hold_req) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R11", "burst completes", n, 0);
        drq_raw = 4'b0;
        repeat (4) @(negedge clk);
        check_idle("R1");
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d expected below %0d", cycles, 50000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            addr_m[i] = '0;
            cnt_m[i]  = '0;
            wr_m[i]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R2 / R12: request without grant, then withdrawn
        begin
            int early = 0;
            ack_en = 0;
            addr_m[2] = 16'h4000; cnt_m[2] = 14'd3; wr_m[2] = 1'b1; en_m[2] = 1'b1;
            drq_raw = 4'b0100;
            @(negedge clk);
            chk(hold_req == 1'b1, "R2", "hold request raised", int'(hold_req), 1);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (adr_stb) early++;
            end
            chk(early == 0, "R2", "no cycle before grant", early, 0);
            chk(hold_req == 1'b1, "R2", "hold held while waiting", int'(hold_req), 1);
            drq_raw = 4'b0;
            @(negedge clk);
            chk(hold_req == 1'b0, "R12", "hold abandoned", int'(hold_req), 0);
            en_m[2] = 1'b0;
            repeat (3) @(negedge clk);
        end

        ack_en = 1;

        // write burst, no waits
        wait_cfg = 0;
        arm(0, 16'h2A10, 3, 1'b1);
        drq_raw = 4'b0001;
        finish_burst();

        // read burst with two waits per byte
        wait_cfg = 2;
        arm(3, 16'h8001, 2, 1'b0);
        drq_raw = 4'b1000;
        finish_burst();

        // two channels together, hand-over after terminal count
        wait_cfg = 0;
        hold_falls = 0;
        arm(1, 16'h0100, 2, 1'b1);
        arm(2, 16'hC0F0, 2, 1'b0);
        drq_raw = 4'b0110;
        finish_burst();
        chk(hold_falls == 1, "R11", "single bus release over hand-over", hold_falls, 1);

        // page crossing with one wait
        wait_cfg = 1;
        arm(0, 16'h12FF, 2, 1'b1);
        drq_raw = 4'b0001;
        finish_burst();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule